// File: doc/BRIEF.md
# Mode-Gated Display Bus Decoder

This block sits between a processor's I/O and memory bus and a display subsystem that holds two controller register sets, one monochrome and one colour, plus a shared byte-wide video RAM. A two-bit display mode (colour, mono or off) decides which controller register window answers and how video memory offsets reach the RAM. Only the window of the active controller sees strobes. Video memory is reached through the upper half of the offset space in colour mode, directly in mono mode, and not at all when the display is off.

A request carries a byte address, a read/write flag, a memory-or-I/O flag and a byte-enable mask. An 8-bit access sets one enable bit. A 16-bit access is split little-endian: lane 0 (data bits 7:0) addresses the given byte, and lane 1 (bits 15:8) addresses the next byte up. Each lane is decoded on its own. Read data comes back registered, one cycle after the request, together with a valid flag. The RAM array itself is inside the block. The controllers are outside it and take write data from the bus directly.

Top module: `dispbus_gate`

## Requirements
- R1: After reset the mode output reads 00 (colour) and `rvalid` is low.
- R2: A cycle with `mode_ld` high loads `mode_in` into the mode from the next cycle on. The encoding is 00 colour, 01 mono, 10 off, and a load of 11 is stored as 10. Without a load the mode holds.
- R3: An enabled I/O lane whose byte address lies in 0x03B0–0x03BF raises that lane's `mono_wr` or `mono_rd` strobe only while the mode is mono. Its `reg_off` field carries the low 4 address bits, and a read returns that lane's `mono_rdata` byte.
- R4: An enabled I/O lane in 0x03D0–0x03DF raises that lane's `cga_wr` or `cga_rd` strobe only while the mode is colour, and a read returns that lane's `cga_rdata` byte.
- R5: An enabled I/O read lane that no active window claims returns 0xFF, and an I/O write to it raises no strobe.
- R6: In colour mode, a memory lane at offset ≥ 0x8000 reaches RAM address (offset − 0x8000), taking its low `RAM_AW` bits. Below 0x8000 reads return 0x00 and writes leave the RAM unchanged.
- R7: In mono mode, a memory lane reaches the RAM at the low `RAM_AW` bits of its offset, with no translation.
- R8: In off mode, every memory read lane returns 0x00 and every memory write leaves the RAM unchanged.
- R9: Lane 1 addresses byte (addr + 1), wrapping at 16 bits, and is decoded on its own, so a 16-bit access may straddle a window or the colour boundary. A lane whose enable bit is clear has no effect and reads 0x00.
- R10: A read request gives `rvalid` high with its `rdata` exactly one cycle later. A write request, or no request, leaves `rvalid` low in the following cycle.
- R11: An access in the same cycle as a mode load is decoded with the mode in force before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Load strobe for the display mode |
| mode_in | input | 2 | Mode value to load |
| req | input | 1 | Bus access request |
| is_mem | input | 1 | 1 = video memory access, 0 = I/O access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Byte address of lane 0 |
| be | input | 2 | Byte enables, bit k for lane k |
| wdata | input | 16 | Write data, lane k in bits 8k+7:8k |
| mode | output | 2 | Current display mode |
| mono_wr | output | 2 | Per-lane write strobe to the mono registers |
| mono_rd | output | 2 | Per-lane read strobe to the mono registers |
| cga_wr | output | 2 | Per-lane write strobe to the colour registers |
| cga_rd | output | 2 | Per-lane read strobe to the colour registers |
| reg_off | output | 8 | Per-lane register index, 4 bits per lane |
| mono_rdata | input | 16 | Per-lane read bytes from the mono registers |
| cga_rdata | input | 16 | Per-lane read bytes from the colour registers |
| rvalid | output | 1 | Read data valid |
| rdata | output | 16 | Registered read data |

## Verification
The bench aims at the lane that straddles a boundary: a word at 0x03BF, where the upper byte leaves the mono window, and a word at 0x7FFF in colour mode, where only the upper byte reaches RAM. A design that decoded the word as a whole would either strobe a register that does not exist or write a RAM byte that should not change. Colour writes below 0x8000 and off-mode writes are read back later through mono mode. An aliasing bug therefore shows up as a corrupted byte and not as silence. A mode load in the same cycle as a mono window write checks that the old mode still gates the write, and a load of the reserved code 11 must come back as off.

// File: rtl/dispbus_gate_pkg.sv
package dispbus_gate_pkg;

   typedef enum logic [1:0] {
      MODE_COLOUR = 2'b00,
      MODE_MONO   = 2'b01,
      MODE_OFF    = 2'b10
   } dmode_e;

   typedef enum logic [2:0] {
      SRC_ZERO = 3'd0,
      SRC_FF   = 3'd1,
      SRC_MONO = 3'd2,
      SRC_CGA  = 3'd3,
      SRC_RAM  = 3'd4
   } lsrc_e;

   // the reserved code folds onto the off state
   function automatic dmode_e fold_mode(input logic [1:0] raw);
      case (raw)
         2'b00:   fold_mode = MODE_COLOUR;
         2'b01:   fold_mode = MODE_MONO;
         default: fold_mode = MODE_OFF;
      endcase
   endfunction

endpackage

// File: rtl/dispbus_mode_reg.sv
module dispbus_mode_reg
   import dispbus_gate_pkg::*;
#(
   parameter dmode_e RESET_MODE = MODE_COLOUR
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [1:0] din,
   output dmode_e     mode_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  mode_q <= RESET_MODE;
      else if (ld) mode_q <= fold_mode(din);
   end
endmodule

// File: rtl/dispbus_lane_dec.sv
module dispbus_lane_dec
   import dispbus_gate_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              RAM_AW    = 10,
   parameter int              WIN_AW    = 4,
   parameter logic [ADDR_W-1:0] MONO_BASE = 16'h03B0,
   parameter logic [ADDR_W-1:0] CGA_BASE  = 16'h03D0,
   parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000
) (
   input  dmode_e              mode,
   input  logic                en,
   input  logic                is_mem,
   input  logic [ADDR_W-1:0]   addr,
   output logic                mono_sel,
   output logic                cga_sel,
   output logic                ram_en,
   output logic [RAM_AW-1:0]   ram_addr,
   output lsrc_e               src
);
   logic              in_mono, in_cga;
   logic [ADDR_W-1:0] hi_off;

   assign in_mono = (addr[ADDR_W-1:WIN_AW] == MONO_BASE[ADDR_W-1:WIN_AW]);
   assign in_cga  = (addr[ADDR_W-1:WIN_AW] == CGA_BASE[ADDR_W-1:WIN_AW]);
   assign hi_off  = addr - VRAM_BASE;

   always_comb begin
      mono_sel = 1'b0;
      cga_sel  = 1'b0;
      ram_en   = 1'b0;
      ram_addr = '0;
      src      = SRC_ZERO;
      if (en) begin
         if (is_mem) begin
            case (mode)
               MODE_COLOUR: begin
                  if (addr >= VRAM_BASE) begin
                     ram_en   = 1'b1;
                     ram_addr = hi_off[RAM_AW-1:0];
                  end
               end
               MODE_MONO: begin
                  ram_en   = 1'b1;
                  ram_addr = addr[RAM_AW-1:0];
               end
               default: ram_en = 1'b0;
            endcase
            src = ram_en ? SRC_RAM : SRC_ZERO;
         end else if (in_mono && mode == MODE_MONO) begin
            mono_sel = 1'b1;
            src      = SRC_MONO;
         end else if (in_cga && mode == MODE_COLOUR) begin
            cga_sel = 1'b1;
            src     = SRC_CGA;
         end else begin
            src = SRC_FF;
         end
      end
   end
endmodule

// File: rtl/dispbus_vram.sv
module dispbus_vram #(
   parameter int LANES = 2,
   parameter int AW    = 10
) (
   input  logic                clk,
   input  logic [LANES-1:0]    wr,
   input  logic [LANES-1:0]    rd,
   input  logic [LANES*AW-1:0] addr,
   input  logic [LANES*8-1:0]  wdata,
   output logic [LANES*8-1:0]  q
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (wr[k]) mem[addr[k*AW +: AW]] <= wdata[k*8 +: 8];
         if (rd[k]) q[k*8 +: 8] <= mem[addr[k*AW +: AW]];
      end
   end
endmodule

// File: rtl/dispbus_gate.sv
module dispbus_gate
   import dispbus_gate_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                LANES     = 2,
   parameter int                RAM_AW    = 10,
   parameter int                WIN_AW    = 4,
   parameter logic [ADDR_W-1:0] MONO_BASE = 16'h03B0,
   parameter logic [ADDR_W-1:0] CGA_BASE  = 16'h03D0,
   parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000,
   localparam int               DATA_W    = 8 * LANES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_ld,
   input  logic [1:0]              mode_in,
   input  logic                    req,
   input  logic                    is_mem,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        be,
   input  logic [DATA_W-1:0]       wdata,
   output logic [1:0]              mode,
   output logic [LANES-1:0]        mono_wr,
   output logic [LANES-1:0]        mono_rd,
   output logic [LANES-1:0]        cga_wr,
   output logic [LANES-1:0]        cga_rd,
   output logic [LANES*WIN_AW-1:0] reg_off,
   input  logic [DATA_W-1:0]       mono_rdata,
   input  logic [DATA_W-1:0]       cga_rdata,
   output logic                    rvalid,
   output logic [DATA_W-1:0]       rdata
);
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("dispbus_gate: LANES out of range");
   end
   if (RAM_AW > ADDR_W || WIN_AW >= ADDR_W) begin : g_bad_widths
      $error("dispbus_gate: RAM_AW or WIN_AW too wide");
   end

   dmode_e                 mode_q;
   logic [LANES-1:0]       mono_sel, cga_sel, ram_en;
   logic [LANES*RAM_AW-1:0] ram_addr;
   logic [DATA_W-1:0]      ram_q;
   lsrc_e                  src   [LANES];
   lsrc_e                  src_q [LANES];
   logic [7:0]             regb_q[LANES];
   logic                   rd_req;

   assign rd_req = req & ~we;
   assign mode   = mode_q;

   dispbus_mode_reg #(.RESET_MODE(MODE_COLOUR)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (mode_ld),
      .din    (mode_in),
      .mode_q (mode_q)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [ADDR_W-1:0] lane_addr;
      logic [RAM_AW-1:0] lane_ram;

      assign lane_addr = addr + ADDR_W'(k);

      dispbus_lane_dec #(
         .ADDR_W    (ADDR_W),
         .RAM_AW    (RAM_AW),
         .WIN_AW    (WIN_AW),
         .MONO_BASE (MONO_BASE),
         .CGA_BASE  (CGA_BASE),
         .VRAM_BASE (VRAM_BASE)
      ) u_dec (
         .mode     (mode_q),
         .en       (req & be[k]),
         .is_mem   (is_mem),
         .addr     (lane_addr),
         .mono_sel (mono_sel[k]),
         .cga_sel  (cga_sel[k]),
         .ram_en   (ram_en[k]),
         .ram_addr (lane_ram),
         .src      (src[k])
      );

      assign ram_addr[k*RAM_AW +: RAM_AW] = lane_ram;
      assign reg_off[k*WIN_AW +: WIN_AW]  = lane_addr[WIN_AW-1:0];
      assign mono_wr[k] = mono_sel[k] & we;
      assign mono_rd[k] = mono_sel[k] & ~we;
      assign cga_wr[k]  = cga_sel[k] & we;
      assign cga_rd[k]  = cga_sel[k] & ~we;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_q[k]  <= SRC_ZERO;
            regb_q[k] <= '0;
         end else begin
            src_q[k]  <= rd_req ? src[k] : SRC_ZERO;
            regb_q[k] <= (src[k] == SRC_MONO) ? mono_rdata[k*8 +: 8]
                                              : cga_rdata[k*8 +: 8];
         end
      end

      always_comb begin
         case (src_q[k])
            SRC_FF:            rdata[k*8 +: 8] = 8'hFF;
            SRC_MONO, SRC_CGA: rdata[k*8 +: 8] = regb_q[k];
            SRC_RAM:           rdata[k*8 +: 8] = ram_q[k*8 +: 8];
            default:           rdata[k*8 +: 8] = 8'h00;
         endcase
      end
   end

   dispbus_vram #(.LANES(LANES), .AW(RAM_AW)) u_vram (
      .clk   (clk),
      .wr    (ram_en & {LANES{we}}),
      .rd    (ram_en & {LANES{~we}}),
      .addr  (ram_addr),
      .wdata (wdata),
      .q     (ram_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= rd_req;
   end
endmodule

// File: rtl/dispbus_gate_chk.sv
module dispbus_gate_chk #(
   parameter int                ADDR_W    = 16,
   parameter int                LANES     = 2,
   parameter logic [ADDR_W-1:0] MONO_BASE = 16'h03B0,
   parameter int                WIN_AW    = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mode_ld,
   input logic [1:0]           mode_in,
   input logic                 req,
   input logic                 is_mem,
   input logic                 we,
   input logic [ADDR_W-1:0]    addr,
   input logic [LANES-1:0]     be,
   input logic [1:0]           mode,
   input logic [LANES-1:0]     mono_wr,
   input logic [LANES-1:0]     mono_rd,
   input logic [LANES-1:0]     cga_wr,
   input logic [LANES-1:0]     cga_rd,
   input logic                 rvalid,
   input logic [8*LANES-1:0]   rdata
);
   logic rd_mono_win0;
   assign rd_mono_win0 = req && !is_mem && !we && be[0] &&
                         addr[ADDR_W-1:WIN_AW] == MONO_BASE[ADDR_W-1:WIN_AW];

   p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11);
   p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ld |=> $stable(mode));
   p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ld && mode_in != 2'b11) |=> mode == $past(mode_in));
   p_mono_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|mono_wr || |mono_rd) |-> mode == 2'b01);
   p_cga_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|cga_wr || |cga_rd) |-> mode == 2'b00);
   p_ff_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mono_win0 && mode != 2'b01) |=> rdata[7:0] == 8'hFF);
   p_low_half_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && is_mem && !we && be[0] && mode == 2'b00 && !addr[ADDR_W-1])
      |=> rdata[7:0] == 8'h00);
   p_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && is_mem && !we && be[0] && mode == 2'b10) |=> rdata[7:0] == 8'h00);
   p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we) |=> rvalid);
   p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && !we) |=> !rvalid);
endmodule

bind dispbus_gate dispbus_gate_chk #(
   .ADDR_W    (ADDR_W),
   .LANES     (LANES),
   .MONO_BASE (MONO_BASE),
   .WIN_AW    (WIN_AW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_ld (mode_ld),
   .mode_in (mode_in),
   .req     (req),
   .is_mem  (is_mem),
   .we      (we),
   .addr    (addr),
   .be      (be),
   .mode    (mode),
   .mono_wr (mono_wr),
   .mono_rd (mono_rd),
   .cga_wr  (cga_wr),
   .cga_rd  (cga_rd),
   .rvalid  (rvalid),
   .rdata   (rdata)
);

// File: tb/dispbus_gate_tb.sv
module dispbus_gate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_ld = 1'b0;
   logic [1:0]  mode_in = 2'b00;
   logic        req = 1'b0, is_mem = 1'b0, we = 1'b0;
   logic [15:0] addr = '0;
   logic [1:0]  be = '0;
   logic [15:0] wdata = '0;
   logic [1:0]  mode;
   logic [1:0]  mono_wr, mono_rd, cga_wr, cga_rd;
   logic [7:0]  reg_off;
   logic [15:0] mono_rdata, cga_rdata;
   logic        rvalid;
   logic [15:0] rdata;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   // controller models: byte = {tag nibble, register index}
   assign mono_rdata = {4'hB, reg_off[7:4], 4'hB, reg_off[3:0]};
   assign cga_rdata  = {4'hD, reg_off[7:4], 4'hD, reg_off[3:0]};

   dispbus_gate u_dut (
      .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_in(mode_in),
      .req(req), .is_mem(is_mem), .we(we), .addr(addr), .be(be), .wdata(wdata),
      .mode(mode), .mono_wr(mono_wr), .mono_rd(mono_rd), .cga_wr(cga_wr),
      .cga_rd(cga_rd), .reg_off(reg_off), .mono_rdata(mono_rdata),
      .cga_rdata(cga_rdata), .rvalid(rvalid), .rdata(rdata)
   );

   // {mode, is_mem, we, addr, be, wdata, expect}
   // expect: read -> rdata; write -> {12'h0, cga_wr, mono_wr}
   localparam int NV = 21;
   localparam logic [53:0] VEC [NV] = '{
      {2'd1, 1'b1, 1'b1, 16'h0010, 2'b11, 16'h5566, 16'h0000}, // R7 write
      {2'd0, 1'b1, 1'b1, 16'h0010, 2'b01, 16'h00EE, 16'h0000}, // R6 low write ignored
      {2'd0, 1'b1, 1'b0, 16'h8010, 2'b11, 16'h0000, 16'h5566}, // R6 upper half map
      {2'd1, 1'b1, 1'b0, 16'h0010, 2'b11, 16'h0000, 16'h5566}, // R7 / R6 unchanged
      {2'd0, 1'b1, 1'b0, 16'h0010, 2'b11, 16'h0000, 16'h0000}, // R6 low read zero
      {2'd0, 1'b1, 1'b1, 16'h7FFF, 2'b11, 16'hAB77, 16'h0000}, // R9 straddle
      {2'd1, 1'b1, 1'b0, 16'h0000, 2'b01, 16'h0000, 16'h00AB}, // R9 lane1 off
      {2'd2, 1'b1, 1'b1, 16'h0000, 2'b11, 16'h9999, 16'h0000}, // R8 write ignored
      {2'd2, 1'b1, 1'b0, 16'h0000, 2'b11, 16'h0000, 16'h0000}, // R8 read zero
      {2'd1, 1'b1, 1'b0, 16'h0400, 2'b01, 16'h0000, 16'h00AB}, // R7 wrap / R8
      {2'd0, 1'b0, 1'b0, 16'h03D4, 2'b11, 16'h0000, 16'hD5D4}, // R4 read
      {2'd0, 1'b0, 1'b0, 16'h03B4, 2'b11, 16'h0000, 16'hFFFF}, // R5
      {2'd1, 1'b0, 1'b0, 16'h03BE, 2'b11, 16'h0000, 16'hBFBE}, // R3 read
      {2'd1, 1'b0, 1'b0, 16'h03BF, 2'b11, 16'h0000, 16'hFFBF}, // R9 window edge
      {2'd1, 1'b0, 1'b0, 16'h03D0, 2'b11, 16'h0000, 16'hFFFF}, // R5
      {2'd2, 1'b0, 1'b0, 16'h03D0, 2'b01, 16'h0000, 16'h00FF}, // R5 off
      {2'd1, 1'b0, 1'b1, 16'h03B0, 2'b11, 16'h1234, 16'h0003}, // R3 write
      {2'd0, 1'b0, 1'b1, 16'h03B0, 2'b11, 16'h1234, 16'h0000}, // R5 dropped
      {2'd0, 1'b0, 1'b1, 16'h03DF, 2'b11, 16'h1234, 16'h0004}, // R4 / R9 edge
      {2'd2, 1'b0, 1'b1, 16'h03DF, 2'b11, 16'h1234, 16'h0000}, // R5 off
      {2'd0, 1'b0, 1'b0, 16'h03CF, 2'b10, 16'h0000, 16'hD000}  // R9 lane0 off
   };

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      mode_ld = 1'b1;
      mode_in = m;
      @(negedge clk);
      mode_ld = 1'b0;
   endtask

   // drive at a falling edge; strobes sampled 1 ns later, read result at next falling edge
   task automatic access(input logic m_mem, input logic m_we, input logic [15:0] a,
                         input logic [1:0] b, input logic [15:0] d,
                         output logic [3:0] strb, output logic rv, output logic [15:0] rd);
      @(negedge clk);
      req = 1'b1; is_mem = m_mem; we = m_we; addr = a; be = b; wdata = d;
      #1 strb = {cga_wr, mono_wr};
      @(negedge clk);
      rv = rvalid;
      rd = rdata;
      req = 1'b0; we = 1'b0; be = '0;
   endtask

   initial begin
      logic [3:0]  strb;
      logic        rv;
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset mode", 32'(mode), 32'h0);
      check("R1 reset rvalid", 32'(rvalid), 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [53:0] v;
         v = VEC[i];
         if (mode !== v[53:52]) set_mode(v[53:52]);
         access(v[51], v[50], v[49:34], v[33:32], v[31:16], strb, rv, rd);
         if (v[50]) begin
            check($sformatf("R3/R4/R5 vec%0d strobes", i), 32'(strb), 32'(v[3:0]));
            check($sformatf("R10 vec%0d no rvalid on write", i), 32'(rv), 32'h0);
         end else begin
            check($sformatf("R3-R9 vec%0d rdata/R10 rvalid", i),
                  {15'h0, rv, rd}, {15'h0, 1'b1, v[15:0]});
         end
      end

      // R2: reserved code loads as off
      set_mode(2'b11);
      #1 check("R2 load 11 as off", 32'(mode), 32'h2);
      // R2: mode holds without a load
      repeat (3) @(negedge clk);
      check("R2 hold", 32'(mode), 32'h2);

      // R11: access in the load cycle uses the old mode
      set_mode(2'b01);
      @(negedge clk);
      mode_ld = 1'b1; mode_in = 2'b00;
      req = 1'b1; is_mem = 1'b0; we = 1'b1; addr = 16'h03B0; be = 2'b11;
      #1 check("R11 old mode gates strobe", 32'({cga_wr, mono_wr}), 32'h3);
      @(negedge clk);
      mode_ld = 1'b0; req = 1'b0; we = 1'b0; be = '0;
      check("R2 new mode after load", 32'(mode), 32'h0);
      check("R10 no rvalid after write", 32'(rvalid), 32'h0);

      // R3: read strobe and register index on a mono read
      set_mode(2'b01);
      @(negedge clk);
      req = 1'b1; is_mem = 1'b0; we = 1'b0; addr = 16'h03B7; be = 2'b01;
      #1 check("R3 read strobe and index", {24'h0, mono_rd, cga_rd, reg_off[3:0]},
               {24'h0, 2'b01, 2'b00, 4'h7});
      @(negedge clk);
      req = 1'b0;
      check("R3 read data", 32'(rdata), 32'h00B7);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule